// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side engine that services an interrupt. At an instruction boundary it picks one request from the pending sources. The sources are a divide fault, a software interrupt instruction, a conditional overflow trap, a non-maskable request, a maskable request and the single-step trap. The block then saves the machine state on the stack and loads the new code segment and instruction pointer from the vector table. The save and the load both go through a single word-wide memory port.

The same engine also runs the return sequence. That sequence restores the instruction pointer, the code segment and the flag word from the stack. The surrounding core supplies the current flags and the segment and pointer registers at the boundary. It takes the updated values back when the block raises a one-cycle completion pulse. A physical address is the segment shifted left by four plus the offset, modulo 2^20.

Top module: `trap_sequencer`

## Requirements
- R1: At a boundary (`boundary_i` high while idle, `iret_i` low), exactly one source is taken, in this order: divide fault (vector 0), then software request (vector `swi_type_i`), then overflow trap (vector 4, only when flag bit 11 is 1), then latched NMI (vector 2), then INTR, then single-step (vector 1).
- R2: An entry writes three words, each after SP has been lowered by 2. The flag word goes to SS:SP-2, CS to SS:SP-4 and IP to SS:SP-6, with offsets wrapping at 16 bits. At completion `sp_o` is SP-6.
- R3: The flag word written to the stack is `flags_i` unchanged. The flags presented at completion of an entry are `flags_i` with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R4: After the pushes, the new IP is read from physical address vector×4 and the new CS from vector×4+2. They appear on `ip_o` and `cs_o`.
- R5: A rising edge on `nmi_i` is latched and stays pending until an NMI entry is accepted. A level held high after service starts nothing further.
- R6: INTR is taken only when flag bit 9 is 1 at the boundary, and it uses `intr_type_i` as its vector. When bit 9 is 0 there is no memory traffic and `busy_o` stays low.
- R7: With nothing higher pending, flag bit 8 equal to 1 at a boundary starts a single-step entry through vector 1.
- R8: An overflow trap request with flag bit 11 equal to 0 gives a one-cycle `skip_o` pulse in the cycle after the boundary. It causes no memory transaction and leaves `cs_o`, `ip_o`, `sp_o` and `flags_o` unchanged. It also consumes that boundary, so lower sources wait.
- R9: `iret_i` at a boundary takes precedence over every request. It reads IP from SS:SP, CS from SS:SP+2 and flags from SS:SP+4, performs no write, and ends with `sp_o` = SP+6.
- R10: A memory transfer completes in a cycle where `mem_valid_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, the address, write data and direction are held stable.
- R11: `done_o` is a single-cycle pulse after the last load, when all outputs carry their final values. `busy_o` is high from the cycle after acceptance through the `done_o` cycle.
- R12: After reset, `mem_valid_o`, `busy_o`, `done_o` and `skip_o` are low and the register outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe; requests are evaluated here |
| iret_i | input | 1 | Return instruction completing at this boundary |
| div_err_i | input | 1 | Divide fault request |
| swi_req_i | input | 1 | Software interrupt instruction request |
| swi_type_i | input | 8 | Vector number of the software request |
| into_i | input | 1 | Conditional overflow trap instruction |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| intr_type_i | input | 8 | Vector number supplied with the maskable request |
| flags_i | input | 16 | Current flag word |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer (return address) |
| ss_i | input | 16 | Stack segment |
| sp_i | input | 16 | Current stack pointer |
| mem_valid_o | output | 1 | Memory request valid |
| mem_write_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Physical word address |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Memory accepts / returns data this cycle |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| cs_o | output | 16 | Resulting code segment |
| ip_o | output | 16 | Resulting instruction pointer |
| sp_o | output | 16 | Resulting stack pointer |
| flags_o | output | 16 | Resulting flag word |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| skip_o | output | 1 | One-cycle pulse: overflow trap skipped |

## Verification
The bench raises a divide fault, a software request, an NMI edge and an enabled INTR together, then drains them one boundary at a time. A wrong priority ladder shows up as the wrong vector or a lost NMI. It also checks that a held NMI level does not start a second entry, that INTR with the enable bit clear stays silent, and that a clear overflow flag yields a skip pulse with no bus traffic. Stack pointers near zero and a high stack segment exercise offset and physical-address wrap. A return issued while INTR is pending must produce reads only. Wait states on the memory port catch a design that drops or alters a request before it is accepted.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 20;
  localparam int TYPE_W = 8;
  localparam int SEG_SHIFT = 4;

  // flag bit positions the sequencer reads or clears
  localparam int IF_POS = 9;
  localparam int TF_POS = 8;
  localparam int OF_POS = 11;

  // fixed vector numbers
  localparam int DIV_VEC  = 0;
  localparam int STEP_VEC = 1;
  localparam int NMI_VEC  = 2;
  localparam int OVF_VEC  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_VEC_IP,
    ST_VEC_CS,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_FL,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_DIV,
    SRC_SWI,
    SRC_OVF,
    SRC_NMI,
    SRC_INTR,
    SRC_STEP
  } src_e;

endpackage

// File: rtl/nmi_latch.sv
module nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o
);

  logic prev_q;
  logic pend_q;
  logic rise_w;

  assign rise_w = lvl_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | rise_w;
    end
  end

  assign pend_o = pend_q;

  // a pending NMI is never lost until it is serviced
  p_nmi_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o && !clr_i |=> pend_o);

endmodule

// File: rtl/trap_arb.sv
module trap_arb
  import trap_seq_pkg::*;
#(
  parameter int TW = TYPE_W
) (
  input  logic          div_err_i,
  input  logic          swi_req_i,
  input  logic [TW-1:0] swi_type_i,
  input  logic          into_i,
  input  logic          of_i,
  input  logic          nmi_pend_i,
  input  logic          intr_i,
  input  logic          if_i,
  input  logic [TW-1:0] intr_type_i,
  input  logic          tf_i,
  output logic          take_o,
  output logic          skip_o,
  output src_e          src_o,
  output logic [TW-1:0] type_o
);

  always_comb begin
    take_o = 1'b1;
    skip_o = 1'b0;
    src_o  = SRC_NONE;
    type_o = '0;
    if (div_err_i) begin
      src_o  = SRC_DIV;
      type_o = TW'(DIV_VEC);
    end else if (swi_req_i) begin
      src_o  = SRC_SWI;
      type_o = swi_type_i;
    end else if (into_i) begin
      if (of_i) begin
        src_o  = SRC_OVF;
        type_o = TW'(OVF_VEC);
      end else begin
        take_o = 1'b0;
        skip_o = 1'b1;
      end
    end else if (nmi_pend_i) begin
      src_o  = SRC_NMI;
      type_o = TW'(NMI_VEC);
    end else if (intr_i && if_i) begin
      src_o  = SRC_INTR;
      type_o = intr_type_i;
    end else if (tf_i) begin
      src_o  = SRC_STEP;
      type_o = TW'(STEP_VEC);
    end else begin
      take_o = 1'b0;
    end
  end

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
  import trap_seq_pkg::*;
#(
  parameter int FW  = WORD_W,
  parameter int AW  = ADDR_W,
  parameter int TW  = TYPE_W,
  parameter int SH  = SEG_SHIFT,
  parameter int IFB = IF_POS,
  parameter int TFB = TF_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic          iret_i,
  input  logic          take_i,
  input  logic          skip_i,
  input  logic [TW-1:0] type_i,
  input  logic [FW-1:0] flags_i,
  input  logic [FW-1:0] cs_i,
  input  logic [FW-1:0] ip_i,
  input  logic [FW-1:0] ss_i,
  input  logic [FW-1:0] sp_i,
  output logic          mem_valid_o,
  output logic          mem_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [FW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [FW-1:0] mem_rdata_i,
  output logic [FW-1:0] cs_o,
  output logic [FW-1:0] ip_o,
  output logic [FW-1:0] sp_o,
  output logic [FW-1:0] flags_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          skip_o,
  output logic          accept_o
);

  localparam int VEC_SHIFT = 2;
  localparam int STEP      = 2;

  // ---- address arithmetic ----
  function automatic logic [AW-1:0] seg_off(input logic [FW-1:0] seg,
                                            input logic [FW-1:0] off);
    logic [AW-1:0] base;
    base = AW'(seg) << SH;
    return base + AW'(off);
  endfunction

  function automatic logic [AW-1:0] vec_slot(input logic [TW-1:0] vec,
                                             input logic hi);
    logic [AW-1:0] base;
    base = AW'(vec) << VEC_SHIFT;
    return hi ? base + AW'(STEP) : base;
  endfunction

  function automatic logic [FW-1:0] sp_move(input logic [FW-1:0] sp,
                                            input logic up);
    return up ? sp + FW'(STEP) : sp - FW'(STEP);
  endfunction

  // ---- state ----
  seq_state_e    state_q;
  logic [FW-1:0] fl_q, cs_q, ip_q, ss_q, sp_q;
  logic [TW-1:0] vec_q;
  logic          skip_q;

  logic idle_w, ret_start_w, accept_w, skip_fire_w, fire_w;

  assign idle_w      = (state_q == ST_IDLE);
  assign ret_start_w = idle_w && boundary_i && iret_i;
  assign accept_w    = idle_w && boundary_i && !iret_i && take_i;
  assign skip_fire_w = idle_w && boundary_i && !iret_i && !take_i && skip_i;
  assign fire_w      = mem_valid_o && mem_ready_i;

  // ---- memory request decode ----
  always_comb begin
    mem_valid_o = 1'b0;
    mem_write_o = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_PUSH_FL: begin
        mem_valid_o = 1'b1;
        mem_write_o = 1'b1;
        mem_addr_o  = seg_off(ss_q, sp_move(sp_q, 1'b0));
        mem_wdata_o = fl_q;
      end
      ST_PUSH_CS: begin
        mem_valid_o = 1'b1;
        mem_write_o = 1'b1;
        mem_addr_o  = seg_off(ss_q, sp_move(sp_q, 1'b0));
        mem_wdata_o = cs_q;
      end
      ST_PUSH_IP: begin
        mem_valid_o = 1'b1;
        mem_write_o = 1'b1;
        mem_addr_o  = seg_off(ss_q, sp_move(sp_q, 1'b0));
        mem_wdata_o = ip_q;
      end
      ST_VEC_IP: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = vec_slot(vec_q, 1'b0);
      end
      ST_VEC_CS: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = vec_slot(vec_q, 1'b1);
      end
      ST_POP_IP, ST_POP_CS, ST_POP_FL: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = seg_off(ss_q, sp_q);
      end
      default: ;
    endcase
  end

  // ---- sequencing ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fl_q    <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
      vec_q   <= '0;
      skip_q  <= 1'b0;
    end else begin
      skip_q <= skip_fire_w;
      unique case (state_q)
        ST_IDLE: begin
          if (ret_start_w) begin
            ss_q    <= ss_i;
            sp_q    <= sp_i;
            state_q <= ST_POP_IP;
          end else if (accept_w) begin
            fl_q    <= flags_i;
            cs_q    <= cs_i;
            ip_q    <= ip_i;
            ss_q    <= ss_i;
            sp_q    <= sp_i;
            vec_q   <= type_i;
            state_q <= ST_PUSH_FL;
          end
        end
        ST_PUSH_FL: if (fire_w) begin
          sp_q      <= sp_move(sp_q, 1'b0);
          fl_q[IFB] <= 1'b0;
          fl_q[TFB] <= 1'b0;
          state_q   <= ST_PUSH_CS;
        end
        ST_PUSH_CS: if (fire_w) begin
          sp_q    <= sp_move(sp_q, 1'b0);
          state_q <= ST_PUSH_IP;
        end
        ST_PUSH_IP: if (fire_w) begin
          sp_q    <= sp_move(sp_q, 1'b0);
          state_q <= ST_VEC_IP;
        end
        ST_VEC_IP: if (fire_w) begin
          ip_q    <= mem_rdata_i;
          state_q <= ST_VEC_CS;
        end
        ST_VEC_CS: if (fire_w) begin
          cs_q    <= mem_rdata_i;
          state_q <= ST_DONE;
        end
        ST_POP_IP: if (fire_w) begin
          ip_q    <= mem_rdata_i;
          sp_q    <= sp_move(sp_q, 1'b1);
          state_q <= ST_POP_CS;
        end
        ST_POP_CS: if (fire_w) begin
          cs_q    <= mem_rdata_i;
          sp_q    <= sp_move(sp_q, 1'b1);
          state_q <= ST_POP_FL;
        end
        ST_POP_FL: if (fire_w) begin
          fl_q    <= mem_rdata_i;
          sp_q    <= sp_move(sp_q, 1'b1);
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_o     = cs_q;
  assign ip_o     = ip_q;
  assign sp_o     = sp_q;
  assign flags_o  = fl_q;
  assign busy_o   = !idle_w;
  assign done_o   = (state_q == ST_DONE);
  assign skip_o   = skip_q;
  assign accept_o = accept_w;

  // ---- checks next to the logic they guard ----
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_write_o));

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w && mem_write_o |=> sp_q == FW'($past(sp_q) - FW'(STEP)));

  p_pop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w && !mem_write_o && (state_q == ST_POP_IP || state_q == ST_POP_CS
      || state_q == ST_POP_FL) |=> sp_q == FW'($past(sp_q) + FW'(STEP)));

  p_mask_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PUSH_CS |-> !fl_q[IFB] && !fl_q[TFB]);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_skip_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> !mem_valid_o && !busy_o);

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_seq_pkg::*;
#(
  parameter int FW = WORD_W,
  parameter int AW = ADDR_W,
  parameter int TW = TYPE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic          iret_i,
  input  logic          div_err_i,
  input  logic          swi_req_i,
  input  logic [TW-1:0] swi_type_i,
  input  logic          into_i,
  input  logic          nmi_i,
  input  logic          intr_i,
  input  logic [TW-1:0] intr_type_i,
  input  logic [FW-1:0] flags_i,
  input  logic [FW-1:0] cs_i,
  input  logic [FW-1:0] ip_i,
  input  logic [FW-1:0] ss_i,
  input  logic [FW-1:0] sp_i,
  output logic          mem_valid_o,
  output logic          mem_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [FW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [FW-1:0] mem_rdata_i,
  output logic [FW-1:0] cs_o,
  output logic [FW-1:0] ip_o,
  output logic [FW-1:0] sp_o,
  output logic [FW-1:0] flags_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          skip_o
);

  logic          nmi_pend_w;
  logic          nmi_clr_w;
  logic          take_w;
  logic          skip_req_w;
  src_e          src_w;
  logic [TW-1:0] vec_w;
  logic          accept_w;

  assign nmi_clr_w = accept_w && (src_w == SRC_NMI);

  nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (nmi_i),
    .clr_i  (nmi_clr_w),
    .pend_o (nmi_pend_w)
  );

  trap_arb #(.TW(TW)) u_arb (
    .div_err_i   (div_err_i),
    .swi_req_i   (swi_req_i),
    .swi_type_i  (swi_type_i),
    .into_i      (into_i),
    .of_i        (flags_i[OF_POS]),
    .nmi_pend_i  (nmi_pend_w),
    .intr_i      (intr_i),
    .if_i        (flags_i[IF_POS]),
    .intr_type_i (intr_type_i),
    .tf_i        (flags_i[TF_POS]),
    .take_o      (take_w),
    .skip_o      (skip_req_w),
    .src_o       (src_w),
    .type_o      (vec_w)
  );

  trap_fsm #(.FW(FW), .AW(AW), .TW(TW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_i  (boundary_i),
    .iret_i      (iret_i),
    .take_i      (take_w),
    .skip_i      (skip_req_w),
    .type_i      (vec_w),
    .flags_i     (flags_i),
    .cs_i        (cs_i),
    .ip_i        (ip_i),
    .ss_i        (ss_i),
    .sp_i        (sp_i),
    .mem_valid_o (mem_valid_o),
    .mem_write_o (mem_write_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .cs_o        (cs_o),
    .ip_o        (ip_o),
    .sp_o        (sp_o),
    .flags_o     (flags_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .skip_o      (skip_o),
    .accept_o    (accept_w)
  );

  // a masked INTR never starts an entry when nothing else is requesting
  p_intr_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && !busy_o && !iret_i && intr_i && !flags_i[IF_POS]
      && !div_err_i && !swi_req_i && !into_i && !nmi_pend_w
      && !flags_i[TF_POS] |=> !busy_o);

endmodule

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary_i, iret_i, div_err_i, swi_req_i, into_i, nmi_i, intr_i;
  logic [7:0]  swi_type_i, intr_type_i;
  logic [15:0] flags_i, cs_i, ip_i, ss_i, sp_i;
  logic        mem_valid_o, mem_write_o, mem_ready_i;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i;
  logic [15:0] cs_o, ip_o, sp_o, flags_o;
  logic        busy_o, done_o, skip_o;

  int total = 0;
  int bad   = 0;
  int waits = 0;
  int wcnt  = 0;
  int wr_n  = 0;
  int wr_addr [64];
  int wr_data [64];
  logic [15:0] mem [int];

  always #5 clk = ~clk;

  trap_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .iret_i(iret_i),
    .div_err_i(div_err_i), .swi_req_i(swi_req_i), .swi_type_i(swi_type_i),
    .into_i(into_i), .nmi_i(nmi_i), .intr_i(intr_i), .intr_type_i(intr_type_i),
    .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i), .ss_i(ss_i), .sp_i(sp_i),
    .mem_valid_o(mem_valid_o), .mem_write_o(mem_write_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o), .flags_o(flags_o),
    .busy_o(busy_o), .done_o(done_o), .skip_o(skip_o)
  );

  function automatic int phys(input int seg, input int off);
    return (seg * 16 + (off & 32'hFFFF)) & 32'hFFFFF;
  endfunction

  function automatic logic [15:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  // memory responder: ready decided away from the active edge
  always @(negedge clk) begin
    if (!mem_valid_o || mem_ready_i) wcnt = 0;
    if (mem_valid_o && wcnt >= waits) begin
      mem_ready_i = 1'b1;
      mem_rdata_i = rd(int'(mem_addr_o));
    end else begin
      mem_ready_i = 1'b0;
      if (mem_valid_o) wcnt++;
    end
  end

  always @(posedge clk) begin
    if (mem_valid_o && mem_ready_i && mem_write_o) begin
      wr_addr[wr_n % 64] = int'(mem_addr_o);
      wr_data[wr_n % 64] = int'(mem_wdata_o);
      wr_n++;
    end
  end

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs;
    boundary_i = 0; iret_i = 0; div_err_i = 0; swi_req_i = 0; into_i = 0;
    intr_i = 0; swi_type_i = 0; intr_type_i = 0;
  endtask

  task automatic pulse_boundary;
    boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  task automatic wait_done(input string r);
    bit seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (done_o) seen = 1;
      else @(negedge clk);
    end
    chk({r, " R11 done seen"}, int'(seen), 1);
  endtask

  // one entry; the caller sets the request lines beforehand
  task automatic entry_case(input string r, input int t, input logic [15:0] fl,
                            input logic [15:0] cs, input logic [15:0] ip,
                            input logic [15:0] ss, input logic [15:0] sp);
    int base;
    mem[t * 4]     = 16'(32'h1000 + t);
    mem[t * 4 + 2] = 16'(32'h2000 + t);
    flags_i = fl; cs_i = cs; ip_i = ip; ss_i = ss; sp_i = sp;
    base = wr_n;
    pulse_boundary();
    wait_done(r);
    chk({r, " R2 write count"}, wr_n - base, 3);
    chk({r, " R2 flags addr"}, wr_addr[base % 64], phys(ss, int'(sp) - 2));
    chk({r, " R3 flags word"}, wr_data[base % 64], int'(fl));
    chk({r, " R2 cs addr"}, wr_addr[(base + 1) % 64], phys(ss, int'(sp) - 4));
    chk({r, " R2 cs word"}, wr_data[(base + 1) % 64], int'(cs));
    chk({r, " R2 ip addr"}, wr_addr[(base + 2) % 64], phys(ss, int'(sp) - 6));
    chk({r, " R2 ip word"}, wr_data[(base + 2) % 64], int'(ip));
    chk({r, " R4 new ip"}, int'(ip_o), (32'h1000 + t) & 32'hFFFF);
    chk({r, " R4 new cs"}, int'(cs_o), (32'h2000 + t) & 32'hFFFF);
    chk({r, " R2 final sp"}, int'(sp_o), (int'(sp) - 6) & 32'hFFFF);
    chk({r, " R3 flags out"}, int'(flags_o), int'(fl) & 32'hFCFF);
    @(negedge clk);
    chk({r, " R11 done one cycle"}, int'(done_o), 0);
    chk({r, " R11 busy cleared"}, int'(busy_o), 0);
  endtask

  // boundary that must start nothing
  task automatic quiet_case(input string r, input logic [15:0] fl);
    int base;
    flags_i = fl;
    base = wr_n;
    pulse_boundary();
    repeat (4) @(negedge clk);
    chk({r, " no busy"}, int'(busy_o), 0);
    chk({r, " no writes"}, wr_n - base, 0);
  endtask

  task automatic t_reset;
    chk("R12 valid", int'(mem_valid_o), 0);
    chk("R12 busy", int'(busy_o), 0);
    chk("R12 done", int'(done_o), 0);
    chk("R12 skip", int'(skip_o), 0);
    chk("R12 cs", int'(cs_o), 0);
    chk("R12 sp", int'(sp_o), 0);
  endtask

  task automatic t_swi;
    swi_req_i = 1; swi_type_i = 8'h21;
    entry_case("R2 swi", 32'h21, 16'h0B46, 16'h0F00, 16'h0123, 16'h1234, 16'h0100);
    clear_reqs();
  endtask

  task automatic t_priority;
    nmi_i = 1'b1;
    @(negedge clk);
    div_err_i = 1; swi_req_i = 1; swi_type_i = 8'h33;
    intr_i = 1; intr_type_i = 8'h40;
    entry_case("R1 divide first", 0, 16'h0200, 16'h0A00, 16'h0010, 16'h0800, 16'h0400);
    div_err_i = 0; swi_req_i = 0;
    entry_case("R5 nmi second", 2, 16'h0200, 16'h0A01, 16'h0020, 16'h0800, 16'h0400);
    entry_case("R6 intr third", 32'h40, 16'h0200, 16'h0A02, 16'h0030, 16'h0800, 16'h0400);
    clear_reqs();
    // NMI level still high: no new entry
    quiet_case("R5 held level", 16'h0000);
    nmi_i = 1'b0;
  endtask

  task automatic t_mask_step;
    intr_i = 1; intr_type_i = 8'h50;
    quiet_case("R6 masked intr", 16'h0000);
    entry_case("R7 single step", 1, 16'h0100, 16'h0B00, 16'h0044, 16'h0900, 16'h0200);
    clear_reqs();
  endtask

  task automatic t_into;
    int base;
    logic [15:0] cs_before;
    into_i = 1; intr_i = 1; intr_type_i = 8'h51;
    cs_before = cs_o;
    flags_i = 16'h0200;
    base = wr_n;
    pulse_boundary();
    chk("R8 skip pulse", int'(skip_o), 1);
    chk("R8 no busy", int'(busy_o), 0);
    into_i = 0; intr_i = 0;
    @(negedge clk);
    chk("R8 skip one cycle", int'(skip_o), 0);
    chk("R8 no writes", wr_n - base, 0);
    chk("R8 cs kept", int'(cs_o), int'(cs_before));
    into_i = 1;
    entry_case("R1 overflow taken", 4, 16'h0800, 16'h0C00, 16'h0055, 16'h0900, 16'h0300);
    clear_reqs();
  endtask

  task automatic t_wrap_stall;
    waits = 3;
    swi_req_i = 1; swi_type_i = 8'h05;
    entry_case("R10 stalled wrap", 5, 16'h0302, 16'h7777, 16'h8888, 16'hFFFF, 16'h0002);
    waits = 0;
    clear_reqs();
  endtask

  task automatic t_return;
    int base, s;
    s = phys(32'h0600, 32'h0FFA);
    mem[s] = 16'h4321; mem[s + 2] = 16'h8765; mem[s + 4] = 16'h0A55;
    iret_i = 1; intr_i = 1; intr_type_i = 8'h60;
    flags_i = 16'h0200; ss_i = 16'h0600; sp_i = 16'h0FFA;
    base = wr_n;
    pulse_boundary();
    iret_i = 0; intr_i = 0;
    wait_done("R9 return");
    chk("R9 no writes", wr_n - base, 0);
    chk("R9 ip", int'(ip_o), 32'h4321);
    chk("R9 cs", int'(cs_o), 32'h8765);
    chk("R9 flags", int'(flags_o), 32'h0A55);
    chk("R9 sp", int'(sp_o), 32'h1000);
    @(negedge clk);
    clear_reqs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hang exp=finish");
    finish_run();
  end

  initial begin
    rst_n = 0; nmi_i = 0; mem_ready_i = 0; mem_rdata_i = 0;
    clear_reqs();
    flags_i = 0; cs_i = 0; ip_i = 0; ss_i = 0; sp_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_swi();
    t_priority();
    t_mask_step();
    t_into();
    t_wrap_stall();
    t_return();
    finish_run();
  end

endmodule